// File: doc/BRIEF.md
# Segment Ownership Isolation Checker

This block stands between memory requesters and physical memory and decides, request by request, whether an access may proceed. Physical memory is cut into equal segments; the segment number is the top SEG_BITS bits of the request address. A hardware-held ownership table records, for every segment, whether it is allocated and which virtual machine holds it. No segment is ever held by two machines. A request is granted only when its segment is allocated to the requesting machine. Any other request is aborted and never passed on. The first abort seen while no fault is pending is latched into a fault record.

Requests come from the processor or from a DMA channel. A processor request is checked against the identifier in the active-machine register. A DMA request carries its own machine tag from its channel setup, and that tag is used in place of the register. A configuration port, one operation per cycle, does the following: sets the active machine, allocates and frees segments, sets the divisor of the per-machine segment quota, and clears the fault record. The quota is total segments divided by the divisor, rounded down, and it is recomputed whenever the divisor is written. Every lookup is a single direct index into the table, with no nested translation.

The fault record is a two-state machine. In FAULT_CLEAR, a denied request moves it to FAULT_HELD (transition "capture") and latches the address and effective machine. In FAULT_HELD, further denials are ignored, and a clear operation returns it to FAULT_CLEAR (transition "release"). A clear operation in either state goes to FAULT_CLEAR and takes priority over a denial in the same cycle.

Top module: `seg_iso_top`

## Requirements
- R1: After reset, grant, abort, fault_valid, cfg_ack and cfg_err are low, active_vm is 0, no segment is allocated, and quota equals 2^SEG_BITS / 2^VM_W.
- R2: One cycle after a cycle with req_valid high, exactly one of grant or abort is high. grant is high exactly when segment req_addr[ADDR_W-1 -: SEG_BITS] is allocated to the effective machine. Without req_valid, both stay low. A request is judged against the table as it was before any configuration write in the same cycle.
- R3: The effective machine is req_vm when req_is_dma is 1. It is active_vm when req_is_dma is 0, and req_vm is then ignored.
- R4: A request to an unallocated segment is always aborted, whatever machine issues it.
- R5: cfg_op encodings are: 0 set active machine to cfg_vm, 1 allocate cfg_seg to cfg_vm, 2 free cfg_seg on behalf of cfg_vm, 3 set the quota divisor to cfg_tot, 4 clear the fault record. Codes 5 to 7 are refused and change nothing. Every cycle with cfg_valid high gives cfg_ack high one cycle later, with cfg_err high if the operation was refused.
- R6: An allocate to a segment that is already allocated is refused, and the existing owner is kept.
- R7: An allocate is refused when the target machine already owns quota or more segments. An accepted allocate adds one to that machine's count.
- R8: A free is refused unless the segment is allocated to cfg_vm. An accepted free makes the segment unallocated and lowers the owner's count by one.
- R9: Writing a divisor of 0 is refused and quota is unchanged. Writing a nonzero divisor D sets quota to floor(2^SEG_BITS / D), visible one cycle later.
- R10: An abort that occurs with no fault held sets fault_valid in the same cycle as abort, and records the request address in fault_addr and the effective machine in fault_vm. Later aborts do not change the record. A clear operation drops fault_valid one cycle later, and it overrides a denial in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Memory request present |
| req_is_dma | input | 1 | 1: DMA request using req_vm; 0: processor request |
| req_vm | input | VM_W | Machine tag of a DMA request |
| req_addr | input | ADDR_W | Physical request address |
| grant | output | 1 | Request allowed (one cycle after request) |
| abort | output | 1 | Request denied (one cycle after request) |
| cfg_valid | input | 1 | Configuration operation present |
| cfg_op | input | 3 | Operation code |
| cfg_seg | input | SEG_BITS | Target segment |
| cfg_vm | input | VM_W | Target machine |
| cfg_tot | input | SEG_BITS+1 | Quota divisor |
| cfg_ack | output | 1 | Operation response |
| cfg_err | output | 1 | Operation refused |
| active_vm | output | VM_W | Active-machine register |
| quota | output | SEG_BITS+1 | Current per-machine segment limit |
| fault_valid | output | 1 | Fault record held |
| fault_addr | output | ADDR_W | Address of recorded denial |
| fault_vm | output | VM_W | Effective machine of recorded denial |

## Verification
The assertions assume that reset is held for at least one clock edge before the first request or configuration operation, so that every $past term refers to a defined cycle. They also assume that req_valid and cfg_valid are low while reset is asserted. The bench drives all inputs only at falling edges, keeps both valid inputs low through reset, and raises them only after reset is released. It does allow a request and a configuration operation in the same cycle, so that the clear-over-denial priority and the table-before-write ordering are exercised.

// File: rtl/seg_iso_pkg.sv
`timescale 1ns/1ps
package seg_iso_pkg;
    localparam logic [2:0] OP_SET_VM    = 3'd0;
    localparam logic [2:0] OP_ALLOC     = 3'd1;
    localparam logic [2:0] OP_FREE      = 3'd2;
    localparam logic [2:0] OP_SET_TOT   = 3'd3;
    localparam logic [2:0] OP_CLR_FAULT = 3'd4;

    typedef enum logic [0:0] {
        FAULT_CLEAR = 1'b0,
        FAULT_HELD  = 1'b1
    } fault_state_e;
endpackage

// File: rtl/seg_iso_cfg.sv
`timescale 1ns/1ps
module seg_iso_cfg
    import seg_iso_pkg::*;
#(
    parameter int SEG_BITS = 3,
    parameter int VM_W     = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_valid,
    input  logic [2:0]                     cfg_op,
    input  logic [SEG_BITS-1:0]            cfg_seg,
    input  logic [VM_W-1:0]                cfg_vm,
    input  logic [SEG_BITS:0]              cfg_tot,
    output logic [(1<<SEG_BITS)-1:0]       seg_valid,
    output logic [(1<<SEG_BITS)-1:0][VM_W-1:0] seg_owner,
    output logic [VM_W-1:0]                active_vm,
    output logic [SEG_BITS:0]              quota,
    output logic                           cfg_ack,
    output logic                           cfg_err,
    output logic                           clr_fault
);
    localparam int TSEG  = 1 << SEG_BITS;
    localparam int NVM   = 1 << VM_W;
    localparam int CNT_W = SEG_BITS + 1;

    logic [CNT_W-1:0] owned_cnt [NVM];
    logic             op_ok;

    always_comb begin
        op_ok = 1'b0;
        unique case (cfg_op)
            OP_SET_VM:    op_ok = 1'b1;
            OP_ALLOC:     op_ok = !seg_valid[cfg_seg] && (owned_cnt[cfg_vm] < quota);
            OP_FREE:      op_ok = seg_valid[cfg_seg] && (seg_owner[cfg_seg] == cfg_vm);
            OP_SET_TOT:   op_ok = (cfg_tot != '0);
            OP_CLR_FAULT: op_ok = 1'b1;
            default:      op_ok = 1'b0;
        endcase
    end

    assign clr_fault = cfg_valid && (cfg_op == OP_CLR_FAULT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_valid <= '0;
            seg_owner <= '0;
            active_vm <= '0;
            quota     <= CNT_W'(TSEG / NVM);
            cfg_ack   <= 1'b0;
            cfg_err   <= 1'b0;
            for (int v = 0; v < NVM; v++) owned_cnt[v] <= '0;
        end else begin
            cfg_ack <= cfg_valid;
            cfg_err <= cfg_valid && !op_ok;
            if (cfg_valid && op_ok) begin
                unique case (cfg_op)
                    OP_SET_VM: active_vm <= cfg_vm;
                    OP_ALLOC: begin
                        seg_valid[cfg_seg] <= 1'b1;
                        seg_owner[cfg_seg] <= cfg_vm;
                        owned_cnt[cfg_vm]  <= owned_cnt[cfg_vm] + 1'b1;
                    end
                    OP_FREE: begin
                        seg_valid[cfg_seg] <= 1'b0;
                        owned_cnt[cfg_vm]  <= owned_cnt[cfg_vm] - 1'b1;
                    end
                    OP_SET_TOT: quota <= CNT_W'(TSEG) / cfg_tot;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/seg_iso_check.sv
`timescale 1ns/1ps
module seg_iso_check #(
    parameter int ADDR_W   = 16,
    parameter int SEG_BITS = 3,
    parameter int VM_W     = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               req_valid,
    input  logic                               req_is_dma,
    input  logic [VM_W-1:0]                    req_vm,
    input  logic [ADDR_W-1:0]                  req_addr,
    input  logic [VM_W-1:0]                    active_vm,
    input  logic [(1<<SEG_BITS)-1:0]           seg_valid,
    input  logic [(1<<SEG_BITS)-1:0][VM_W-1:0] seg_owner,
    output logic                               deny_now,
    output logic [VM_W-1:0]                    eff_vm,
    output logic                               grant,
    output logic                               abort
);
    logic [SEG_BITS-1:0] seg_idx;
    logic                owner_hit;

    assign seg_idx   = req_addr[ADDR_W-1 -: SEG_BITS];
    assign eff_vm    = req_is_dma ? req_vm : active_vm;
    assign owner_hit = seg_valid[seg_idx] && (seg_owner[seg_idx] == eff_vm);
    assign deny_now  = req_valid && !owner_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant <= 1'b0;
            abort <= 1'b0;
        end else begin
            grant <= req_valid && owner_hit;
            abort <= deny_now;
        end
    end
endmodule

// File: rtl/seg_iso_fault.sv
`timescale 1ns/1ps
module seg_iso_fault
    import seg_iso_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int VM_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deny_now,
    input  logic              clr_fault,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [VM_W-1:0]   eff_vm,
    output logic              fault_valid,
    output logic [ADDR_W-1:0] fault_addr,
    output logic [VM_W-1:0]   fault_vm
);
    fault_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FAULT_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FAULT_CLEAR: if (clr_fault)     state_d = FAULT_CLEAR;
                         else if (deny_now) state_d = FAULT_HELD;
            FAULT_HELD:  if (clr_fault)     state_d = FAULT_CLEAR;
            default:                        state_d = FAULT_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_addr <= '0;
            fault_vm   <= '0;
        end else if (state_q == FAULT_CLEAR && state_d == FAULT_HELD) begin
            fault_addr <= req_addr;
            fault_vm   <= eff_vm;
        end
    end

    always_comb fault_valid = (state_q == FAULT_HELD);
endmodule

// File: rtl/seg_iso_top.sv
`timescale 1ns/1ps
module seg_iso_top #(
    parameter int ADDR_W   = 16,
    parameter int SEG_BITS = 3,
    parameter int VM_W     = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_is_dma,
    input  logic [VM_W-1:0]     req_vm,
    input  logic [ADDR_W-1:0]   req_addr,
    output logic                grant,
    output logic                abort,
    input  logic                cfg_valid,
    input  logic [2:0]          cfg_op,
    input  logic [SEG_BITS-1:0] cfg_seg,
    input  logic [VM_W-1:0]     cfg_vm,
    input  logic [SEG_BITS:0]   cfg_tot,
    output logic                cfg_ack,
    output logic                cfg_err,
    output logic [VM_W-1:0]     active_vm,
    output logic [SEG_BITS:0]   quota,
    output logic                fault_valid,
    output logic [ADDR_W-1:0]   fault_addr,
    output logic [VM_W-1:0]     fault_vm
);
    localparam int TSEG = 1 << SEG_BITS;

    logic [TSEG-1:0]            seg_valid;
    logic [TSEG-1:0][VM_W-1:0]  seg_owner;
    logic                       clr_fault;
    logic                       deny_now;
    logic [VM_W-1:0]            eff_vm;

    seg_iso_cfg #(.SEG_BITS(SEG_BITS), .VM_W(VM_W)) cfg_i (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_op(cfg_op),
        .cfg_seg(cfg_seg), .cfg_vm(cfg_vm), .cfg_tot(cfg_tot),
        .seg_valid(seg_valid), .seg_owner(seg_owner), .active_vm(active_vm),
        .quota(quota), .cfg_ack(cfg_ack), .cfg_err(cfg_err), .clr_fault(clr_fault)
    );

    seg_iso_check #(.ADDR_W(ADDR_W), .SEG_BITS(SEG_BITS), .VM_W(VM_W)) check_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_dma(req_is_dma),
        .req_vm(req_vm), .req_addr(req_addr), .active_vm(active_vm),
        .seg_valid(seg_valid), .seg_owner(seg_owner), .deny_now(deny_now),
        .eff_vm(eff_vm), .grant(grant), .abort(abort)
    );

    seg_iso_fault #(.ADDR_W(ADDR_W), .VM_W(VM_W)) fault_i (
        .clk(clk), .rst_n(rst_n), .deny_now(deny_now), .clr_fault(clr_fault),
        .req_addr(req_addr), .eff_vm(eff_vm), .fault_valid(fault_valid),
        .fault_addr(fault_addr), .fault_vm(fault_vm)
    );
endmodule

// File: rtl/seg_iso_chk.sv
`timescale 1ns/1ps
module seg_iso_chk
    import seg_iso_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int VM_W   = 2,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              cfg_valid,
    input logic [2:0]        cfg_op,
    input logic [CNT_W-1:0]  cfg_tot,
    input logic              grant,
    input logic              abort,
    input logic              cfg_ack,
    input logic              cfg_err,
    input logic              fault_valid,
    input logic [ADDR_W-1:0] fault_addr,
    input logic [VM_W-1:0]   fault_vm
);
    // R2: each request yields exactly one outcome
    a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (grant ^ abort));
    // R2: no outcome without a request
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(grant || abort));
    // R5: every operation is answered
    a_r5_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> cfg_ack);
    // R9: zero divisor refused
    a_r9_zero_div_err: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_op == OP_SET_TOT && cfg_tot == '0) |=> cfg_err);
    // R5: no error without an operation
    a_r5_err_needs_op: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> cfg_ack);
    // R10: an abort not overridden by a clear leaves a held fault
    a_r10_abort_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !$past(cfg_valid && cfg_op == OP_CLR_FAULT)) |-> fault_valid);
    // R10: held record does not change
    a_r10_record_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && $past(fault_valid)) |-> ($stable(fault_addr) && $stable(fault_vm)));
endmodule

bind seg_iso_top seg_iso_chk #(.ADDR_W(ADDR_W), .VM_W(VM_W), .CNT_W(SEG_BITS+1)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cfg_valid(cfg_valid),
    .cfg_op(cfg_op), .cfg_tot(cfg_tot), .grant(grant), .abort(abort),
    .cfg_ack(cfg_ack), .cfg_err(cfg_err), .fault_valid(fault_valid),
    .fault_addr(fault_addr), .fault_vm(fault_vm)
);

// File: tb/seg_iso_top_tb_top.sv
`timescale 1ns/1ps
module seg_iso_top_tb_top;
    localparam int ADDR_W = 16;
    localparam int SEG_BITS = 3;
    localparam int VM_W = 2;
    localparam int TSEG = 8;
    localparam int NVM = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_is_dma = 0;
    logic [VM_W-1:0] req_vm = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic grant, abort;
    logic cfg_valid = 0;
    logic [2:0] cfg_op = '0;
    logic [SEG_BITS-1:0] cfg_seg = '0;
    logic [VM_W-1:0] cfg_vm = '0;
    logic [SEG_BITS:0] cfg_tot = '0;
    logic cfg_ack, cfg_err;
    logic [VM_W-1:0] active_vm;
    logic [SEG_BITS:0] quota;
    logic fault_valid;
    logic [ADDR_W-1:0] fault_addr;
    logic [VM_W-1:0] fault_vm;

    int checks = 0, errors = 0;

    // model state
    bit m_v [TSEG];
    int m_own [TSEG];
    int m_cnt [NVM];
    int m_quota, m_active;
    bit m_held;
    int m_faddr, m_fvm;

    always #2.5 clk = ~clk;

    seg_iso_top #(.ADDR_W(ADDR_W), .SEG_BITS(SEG_BITS), .VM_W(VM_W)) dut_i (.*);

    task automatic chk(input string tag, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk_addr(input int seg, input int salt);
        return {3'(seg), 13'(salt * 613 + 17)};
    endfunction

    task automatic step(input string tag, input bit cv, input int op, input int seg,
                        input int vm, input int tot, input bit rv, input bit dma,
                        input int rvm, input logic [ADDR_W-1:0] addr);
        bit e_err, e_grant, e_abort;
        int rseg, eff;
        @(negedge clk);
        cfg_valid = cv; cfg_op = 3'(op); cfg_seg = 3'(seg); cfg_vm = 2'(vm); cfg_tot = 4'(tot);
        req_valid = rv; req_is_dma = dma; req_vm = 2'(rvm); req_addr = addr;
        case (op)
            0: e_err = 0;
            1: e_err = m_v[seg] || (m_cnt[vm] >= m_quota);
            2: e_err = !(m_v[seg] && m_own[seg] == vm);
            3: e_err = (tot == 0);
            4: e_err = 0;
            default: e_err = 1;
        endcase
        e_err = cv && e_err;
        rseg = int'(addr[ADDR_W-1 -: SEG_BITS]);
        eff = dma ? rvm : m_active;
        e_grant = rv && m_v[rseg] && (m_own[rseg] == eff);
        e_abort = rv && !e_grant;
        if (cv && op == 4) m_held = 0;
        else if (e_abort && !m_held) begin
            m_held = 1; m_faddr = int'(addr); m_fvm = eff;
        end
        if (cv && !e_err) begin
            case (op)
                0: m_active = vm;
                1: begin m_v[seg] = 1; m_own[seg] = vm; m_cnt[vm]++; end
                2: begin m_v[seg] = 0; m_cnt[vm]--; end
                3: m_quota = TSEG / tot;
                default: ;
            endcase
        end
        @(negedge clk);
        cfg_valid = 0; req_valid = 0;
        chk(tag, {grant, abort} == {e_grant, e_abort}, {grant, abort}, {e_grant, e_abort});
        chk(tag, {cfg_ack, cfg_err} == {cv, e_err}, {cfg_ack, cfg_err}, {cv, e_err});
        chk("R10", fault_valid == m_held && (!m_held ||
            (int'(fault_addr) == m_faddr && int'(fault_vm) == m_fvm)),
            fault_valid ? int'(fault_addr) : -1, m_held ? m_faddr : -1);
        chk("R5", int'(active_vm) == m_active, active_vm, m_active);
        chk("R9", int'(quota) == m_quota, quota, m_quota);
    endtask

    task automatic cfg(input string tag, input int op, input int seg, input int vm, input int tot);
        step(tag, 1, op, seg, vm, tot, 0, 0, 0, '0);
    endtask

    task automatic req(input string tag, input bit dma, input int rvm, input logic [ADDR_W-1:0] a);
        step(tag, 0, 0, 0, 0, 0, 1, dma, rvm, a);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk("WATCHDOG", 0, 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int s = 0; s < TSEG; s++) begin m_v[s] = 0; m_own[s] = 0; end
        for (int v = 0; v < NVM; v++) m_cnt[v] = 0;
        m_quota = TSEG / NVM; m_active = 0; m_held = 0; m_faddr = 0; m_fvm = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", {grant, abort, fault_valid, cfg_ack, cfg_err} == 5'b0,
            {grant, abort, fault_valid, cfg_ack, cfg_err}, 0);
        chk("R1", active_vm == 0, active_vm, 0);
        chk("R1", int'(quota) == TSEG / NVM, quota, TSEG / NVM);

        // R4: every unallocated segment aborts for every machine
        for (int v = 0; v < NVM; v++)
            for (int s = 0; s < TSEG; s++) req("R4", 1, v, mk_addr(s, v));
        req("R3", 0, 3, mk_addr(5, 1));
        cfg("R10", 4, 0, 0, 0);

        // R6 / R7: allocation sweep, quota 2 per machine
        for (int s = 0; s < TSEG; s++)
            for (int v = 0; v < NVM; v++)
                cfg(m_v[s] ? "R6" : "R7", 1, s, v, 0);

        // R2: DMA sweep over all machines and segments
        for (int v = 0; v < NVM; v++)
            for (int s = 0; s < TSEG; s++) req("R2", 1, v, mk_addr(s, s + v));

        // R3: processor sweep with a misleading DMA tag
        for (int v = 0; v < NVM; v++) begin
            cfg("R5", 0, 0, v, 0);
            for (int s = 0; s < TSEG; s++) req("R3", 0, 3 - v, mk_addr(s, v));
        end
        cfg("R10", 4, 0, 0, 0);

        // R8: free rules
        cfg("R8", 2, 0, 1, 0);
        cfg("R8", 2, 0, 0, 0);
        req("R8", 1, 0, mk_addr(0, 9));
        cfg("R8", 2, 0, 0, 0);
        cfg("R7", 1, 0, 1, 0);

        // R9: divisor handling
        cfg("R9", 3, 0, 0, 0);
        cfg("R9", 3, 0, 0, 2);
        cfg("R9", 1, 0, 1, 0);
        req("R2", 1, 1, mk_addr(0, 3));
        cfg("R9", 3, 0, 0, 3);
        cfg("R9", 3, 0, 0, 9);
        cfg("R8", 2, 7, 3, 0);
        cfg("R7", 1, 7, 3, 0);
        cfg("R9", 3, 0, 0, 1);
        cfg("R7", 1, 7, 3, 0);

        // R5: illegal codes refused, state unchanged
        for (int op = 5; op < 8; op++) cfg("R5", op, 7, 0, 0);
        req("R5", 1, 3, mk_addr(7, 2));

        // R2: request sees the table before a same-cycle free
        step("R2", 1, 2, 2, 1, 0, 1, 1, 1, mk_addr(2, 4));
        req("R2", 1, 1, mk_addr(2, 4));

        // R10: first denial kept, later ignored, clear beats denial
        cfg("R10", 4, 0, 0, 0);
        req("R10", 1, 2, mk_addr(3, 5));
        req("R10", 1, 0, mk_addr(4, 6));
        step("R10", 1, 4, 0, 0, 0, 1, 1, 2, mk_addr(1, 7));
        req("R10", 0, 0, mk_addr(6, 8));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule